// File: doc/BRIEF.md
# Scroll and Address Double-Write Latch

This block keeps the video address state that a CPU builds up through three write-only ports: a control port, a scroll port and an address port. The scroll and address ports each take two 8-bit writes in a row. A single first/second toggle, shared by both ports, decides how each byte is used. Each byte lands in its own fields of a 15-bit temporary address register, and one scroll byte also fills a 3-bit fine horizontal offset.

The current address is the 15-bit value that the data port uses. It changes in only two ways. A second write to the address port copies the completed temporary value into it. An increment strobe from the data port advances it by 1, or by 32 when the row step is selected. A read of the status register resets the toggle, so software can resynchronise the write pairing. Increments and copies made during rendering are handled elsewhere.

Top module: `vaddr_latch`

## Requirements
- R1: After reset is asserted, the temporary address, current address, fine X and toggle all read as zero.
- R2: An address-port write with toggle 0 puts data bits 5:0 into temporary bits 13:8 and clears temporary bit 14. All other temporary bits stay as they were, the current address is unchanged, and the toggle becomes 1.
- R3: An address-port write with toggle 1 puts all 8 data bits into temporary bits 7:0. On the same edge the complete updated temporary value is copied into the current address, and the toggle becomes 0.
- R4: A scroll-port write with toggle 0 puts data bits 2:0 into fine X and data bits 7:3 into temporary bits 4:0. The toggle becomes 1.
- R5: A scroll-port write with toggle 1 puts data bits 2:0 into temporary bits 14:12 and data bits 7:3 into temporary bits 9:5. The toggle becomes 0 and the current address is unchanged.
- R6: A control-port write puts data bits 1:0 into temporary bits 11:10. It leaves the toggle, fine X and the current address unchanged.
- R7: A status read clears the toggle. When a status read arrives in the same cycle as a scroll or address write, the write is decoded with the toggle value from before the read, and the toggle ends at 0.
- R8: An increment strobe adds 1 to the current address when incr_step32_i is 0 and 32 when it is 1. The sum wraps modulo 2^15.
- R9: When an increment strobe arrives in the same cycle as an address-port write with toggle 1, the current address takes the new temporary value and the increment is dropped.
- R10: The scroll and address ports share one toggle. A write to either port is treated as the second of a pair if the write just before it, to either port, was a first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control-port write strobe |
| scroll_wr_i | input | 1 | Scroll-port write strobe |
| addr_wr_i | input | 1 | Address-port write strobe |
| wdata_i | input | 8 | Write data for all ports |
| status_rd_i | input | 1 | Status read; clears the toggle |
| incr_i | input | 1 | Data-port increment strobe |
| incr_step32_i | input | 1 | Increment step select: 0 adds 1, 1 adds 32 |
| vaddr_o | output | 15 | Current address |
| taddr_o | output | 15 | Temporary address |
| fine_x_o | output | 3 | Fine horizontal offset |
| toggle_o | output | 1 | Write toggle: 0 means first write, 1 means second write |

## Verification
Two collisions matter. The first is an increment strobe in the same cycle as the address write that completes a pair. The bench provokes it by first running the current address up to a known value with increments. It then raises incr_i together with the second address byte and checks that the current address equals the newly assembled temporary value, with no 1 or 32 added. The second is a status read in the same cycle as a scroll write. The bench checks that the scroll byte lands in the fields chosen by the old toggle and that the toggle still ends at 0.

// File: rtl/vaddr_latch_pkg.sv
package vaddr_latch_pkg;
  localparam int unsigned VADDR_W = 15;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FX_W    = 3;
  typedef logic [VADDR_W-1:0] vaddr_t;
  typedef logic [DATA_W-1:0]  wdata_t;
  typedef logic [FX_W-1:0]    fine_x_t;
endpackage

// File: rtl/vl_toggle.sv
module vl_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clr_i)  q_q <= 1'b0;
    else if (flip_i) q_q <= ~q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/vl_temp_reg.sv
module vl_temp_reg
  import vaddr_latch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ctrl_wr_i,
  input  logic    scroll_wr_i,
  input  logic    addr_wr_i,
  input  logic    second_i,
  input  wdata_t  wdata_i,
  output vaddr_t  t_next_o,
  output vaddr_t  t_o,
  output fine_x_t fine_x_o
);
  vaddr_t  t_q, t_n;
  fine_x_t fx_q, fx_n;

  always_comb begin
    t_n  = t_q;
    fx_n = fx_q;
    if (ctrl_wr_i) t_n[11:10] = wdata_i[1:0];
    if (scroll_wr_i) begin
      if (!second_i) begin
        fx_n      = wdata_i[2:0];
        t_n[4:0]  = wdata_i[7:3];
      end else begin
        t_n[14:12] = wdata_i[2:0];
        t_n[9:5]   = wdata_i[7:3];
      end
    end
    if (addr_wr_i) begin
      if (!second_i) begin
        t_n[13:8] = wdata_i[5:0];
        t_n[14]   = 1'b0;
      end else begin
        t_n[7:0]  = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q  <= '0;
      fx_q <= '0;
    end else begin
      t_q  <= t_n;
      fx_q <= fx_n;
    end
  end

  assign t_next_o = t_n;
  assign t_o      = t_q;
  assign fine_x_o = fx_q;
endmodule

// File: rtl/vl_cur_addr.sv
module vl_cur_addr
  import vaddr_latch_pkg::*;
#(
  parameter int unsigned ROW_STEP = 32
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  vaddr_t load_val_i,
  input  logic   incr_i,
  input  logic   step_row_i,
  output vaddr_t v_o
);
  localparam vaddr_t STEP_ROW = vaddr_t'(ROW_STEP);
  localparam vaddr_t STEP_ONE = vaddr_t'(1);

  vaddr_t v_q;

  // load wins over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     v_q <= '0;
    else if (load_i) v_q <= load_val_i;
    else if (incr_i) v_q <= v_q + (step_row_i ? STEP_ROW : STEP_ONE);
  end

  assign v_o = v_q;
endmodule

// File: rtl/vaddr_latch.sv
module vaddr_latch
  import vaddr_latch_pkg::*;
#(
  parameter int unsigned ROW_STEP = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_wr_i,
  input  logic        scroll_wr_i,
  input  logic        addr_wr_i,
  input  logic [7:0]  wdata_i,
  input  logic        status_rd_i,
  input  logic        incr_i,
  input  logic        incr_step32_i,
  output logic [14:0] vaddr_o,
  output logic [14:0] taddr_o,
  output logic [2:0]  fine_x_o,
  output logic        toggle_o
);
  logic   second;
  vaddr_t t_next;

  vl_toggle u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flip_i (scroll_wr_i | addr_wr_i),
    .clr_i  (status_rd_i),
    .q_o    (second)
  );

  vl_temp_reg u_temp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr_i),
    .scroll_wr_i (scroll_wr_i),
    .addr_wr_i   (addr_wr_i),
    .second_i    (second),
    .wdata_i     (wdata_i),
    .t_next_o    (t_next),
    .t_o         (taddr_o),
    .fine_x_o    (fine_x_o)
  );

  vl_cur_addr #(.ROW_STEP(ROW_STEP)) u_cur (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_wr_i & second),
    .load_val_i (t_next),
    .incr_i     (incr_i),
    .step_row_i (incr_step32_i),
    .v_o        (vaddr_o)
  );

  assign toggle_o = second;
endmodule

// File: rtl/vaddr_latch_chk.sv
module vaddr_latch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_wr_i,
  input logic        scroll_wr_i,
  input logic        addr_wr_i,
  input logic [7:0]  wdata_i,
  input logic        status_rd_i,
  input logic        incr_i,
  input logic        incr_step32_i,
  input logic [14:0] vaddr_o,
  input logic [14:0] taddr_o,
  input logic [2:0]  fine_x_o,
  input logic        toggle_o
);
  always_comb begin
    if (rst_ni) p_one_port_write: assert ($onehot0({ctrl_wr_i, scroll_wr_i, addr_wr_i}));
  end

  p_first_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_wr_i && !toggle_o && !incr_i |=>
      taddr_o[14] == 1'b0 && taddr_o[13:8] == $past(wdata_i[5:0]) && vaddr_o == $past(vaddr_o));

  p_second_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_wr_i && toggle_o |=> vaddr_o == taddr_o && taddr_o[7:0] == $past(wdata_i));

  p_first_scroll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scroll_wr_i && !toggle_o |=>
      fine_x_o == $past(wdata_i[2:0]) && taddr_o[4:0] == $past(wdata_i[7:3]));

  p_second_scroll_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scroll_wr_i && toggle_o && !incr_i |=>
      taddr_o[14:12] == $past(wdata_i[2:0]) && taddr_o[9:5] == $past(wdata_i[7:3])
      && vaddr_o == $past(vaddr_o));

  p_ctrl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !status_rd_i |=>
      taddr_o[11:10] == $past(wdata_i[1:0]) && $stable(toggle_o) && $stable(fine_x_o));

  p_status_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !toggle_o);

  p_incr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incr_i && !(addr_wr_i && toggle_o) |=>
      vaddr_o == 15'($past(vaddr_o) + ($past(incr_step32_i) ? 15'd32 : 15'd1)));

  p_flip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scroll_wr_i || addr_wr_i) && !status_rd_i |=> toggle_o != $past(toggle_o));
endmodule

bind vaddr_latch vaddr_latch_chk u_chk (.*);

// File: tb/sim_vaddr_latch.sv
module sim_vaddr_latch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_wr_i = 1'b0, scroll_wr_i = 1'b0, addr_wr_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic        status_rd_i = 1'b0, incr_i = 1'b0, incr_step32_i = 1'b0;
  logic [14:0] vaddr_o, taddr_o;
  logic [2:0]  fine_x_o;
  logic        toggle_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [14:0] m_t, m_v;
  logic [2:0]  m_fx;
  logic        m_tog;

  always #10 clk_i = ~clk_i;

  vaddr_latch u0 (.*);

  task automatic chk(string tag, string what, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "taddr", taddr_o, m_t);
    chk(tag, "vaddr", vaddr_o, m_v);
    chk(tag, "fine_x", 15'(fine_x_o), 15'(m_fx));
    chk(tag, "toggle", 15'(toggle_o), 15'(m_tog));
  endtask

  // one cycle of stimulus; reference updated from the requirement text
  task automatic step(string tag, logic c, logic s, logic a, logic [7:0] d,
                      logic st, logic inc, logic s32);
    logic old_tog;
    logic [14:0] nt, nv;
    @(negedge clk_i);
    ctrl_wr_i = c; scroll_wr_i = s; addr_wr_i = a; wdata_i = d;
    status_rd_i = st; incr_i = inc; incr_step32_i = s32;
    old_tog = m_tog; nt = m_t; nv = m_v;
    if (c) nt[11:10] = d[1:0];
    if (s) begin
      if (!old_tog) begin m_fx = d[2:0]; nt[4:0] = d[7:3]; end
      else begin nt[14:12] = d[2:0]; nt[9:5] = d[7:3]; end
    end
    if (a) begin
      if (!old_tog) begin nt[13:8] = d[5:0]; nt[14] = 1'b0; end
      else nt[7:0] = d;
    end
    if (a && old_tog) nv = nt;
    else if (inc) nv = m_v + (s32 ? 15'd32 : 15'd1);
    m_tog = st ? 1'b0 : ((s || a) ? ~old_tog : old_tog);
    m_t = nt; m_v = nv;
    @(negedge clk_i);
    ctrl_wr_i = 0; scroll_wr_i = 0; addr_wr_i = 0; status_rd_i = 0; incr_i = 0; incr_step32_i = 0;
    check_all(tag);
  endtask

  task automatic t_reset();
    m_t = '0; m_v = '0; m_fx = '0; m_tog = 1'b0;
    check_all("R1");
  endtask

  task automatic t_addr_pair();
    step("R4", 0, 1, 0, 8'h00, 0, 0, 0);
    step("R5", 0, 1, 0, 8'h07, 0, 0, 0);
    chk("R5", "taddr bit14 set", taddr_o, 15'h7000);
    step("R2", 0, 0, 1, 8'hC2, 0, 0, 0);
    chk("R2", "taddr bit14 cleared", taddr_o, 15'h0200);
    step("R3", 0, 0, 1, 8'h5A, 0, 0, 0);
    chk("R3", "vaddr loaded", vaddr_o, 15'h025A);
  endtask

  task automatic t_scroll_pair();
    step("R4", 0, 1, 0, 8'hAB, 0, 0, 0);
    chk("R4", "fine_x", 15'(fine_x_o), 15'd3);
    step("R5", 0, 1, 0, 8'h6E, 0, 0, 0);
    chk("R5", "taddr", taddr_o, 15'h61B5);
    chk("R5", "vaddr held", vaddr_o, 15'h025A);
  endtask

  task automatic t_ctrl();
    step("R4", 0, 1, 0, 8'h10, 0, 0, 0);
    step("R6", 1, 0, 0, 8'hFF, 0, 0, 0);
    chk("R6", "toggle held", 15'(toggle_o), 15'd1);
    step("R6", 1, 0, 0, 8'h00, 0, 0, 0);
    step("R7", 0, 0, 0, 8'h00, 1, 0, 0);
  endtask

  task automatic t_status_collide();
    step("R4", 0, 1, 0, 8'h11, 0, 0, 0);
    step("R7", 0, 1, 0, 8'hF5, 1, 0, 0);
    chk("R7", "toggle after read+write", 15'(toggle_o), 15'd0);
    step("R7", 0, 1, 0, 8'h3A, 1, 0, 0);
    chk("R7", "fine_x from first-write decode", 15'(fine_x_o), 15'd2);
  endtask

  task automatic t_shared_and_incr();
    step("R10", 0, 0, 1, 8'h3F, 0, 0, 0);
    step("R10", 0, 1, 0, 8'hFF, 0, 0, 0);
    step("R10", 0, 1, 0, 8'hFF, 0, 0, 0);
    step("R10", 0, 0, 1, 8'hFF, 0, 0, 0);
    chk("R10", "vaddr all ones", vaddr_o, 15'h7FFF);
    step("R8", 0, 0, 0, 8'h00, 0, 1, 0);
    chk("R8", "wrap +1", vaddr_o, 15'h0000);
    for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, 8'h00, 0, 1, 1);
    chk("R8", "three +32", vaddr_o, 15'h0060);
    step("R2", 0, 0, 1, 8'h3F, 0, 0, 0);
    step("R5", 0, 1, 0, 8'hFF, 0, 0, 0);
    step("R4", 0, 1, 0, 8'h20, 0, 0, 0);
    step("R3", 0, 0, 1, 8'hE5, 0, 0, 0);
    chk("R3", "vaddr 7FE5", vaddr_o, 15'h7FE5);
    step("R8", 0, 0, 0, 8'h00, 0, 1, 1);
    chk("R8", "wrap +32", vaddr_o, 15'h0005);
  endtask

  task automatic t_incr_load_collide();
    for (int i = 0; i < 4; i++) step("R8", 0, 0, 0, 8'h00, 0, 1, 0);
    step("R2", 0, 0, 1, 8'h12, 0, 1, 0);
    step("R9", 0, 0, 1, 8'h34, 0, 1, 1);
    chk("R9", "load beats incr", vaddr_o, taddr_o);
    chk("R9", "vaddr value", vaddr_o, {m_t[14:8], 8'h34});
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");
    t_addr_pair();
    t_scroll_pair();
    t_ctrl();
    t_status_collide();
    t_shared_and_incr();
    t_incr_load_collide();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule